// File: doc/BRIEF.md
# Paired-Wavefront Bundle Issue Sequencer

This block sequences instruction bundles into one wide SIMD engine of 16 lanes by 4 operation slots. Each bundle holds up to four independent operations that run side by side. A wavefront of 64 elements crosses the 16 lanes in four consecutive quarters. Results take 8 cycles to come back, so one wavefront can only issue its next bundle 8 cycles after its previous one. The sequencer hides that wait by alternating the two wavefronts of a pair: four quarters of the even wavefront, then four quarters of the odd one, then the even one again with its next bundle.

A run starts with a one-cycle `start` pulse that latches the wavefront count and the bundle count. Pairs (0,1), (2,3) and so on run in turn. Each pair issues all of its bundles before the next pair begins. An odd count leaves the last wavefront alone, and it idles for four cycles between its bundles. The sequencer reports the bundle index it is issuing, and the surrounding logic returns that bundle's slot-valid mask on `slot_mask`. When the last issue has drained through the 8-cycle latency, `done` pulses for one cycle and `cycle_cnt` then holds the length of the run.

Top module: `vliw_wave_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, `issue_vld` and `done` are 0 and `slot_en` is 0.
- R2: Counting k from 0 at the first busy cycle, while k < 8·N·P (N bundles, P = ceil(W/2) pairs for W wavefronts), the quarter is k mod 4 (0..3), the bundle is (k/8) mod N, and the pair is k/(8·N).
- R3: In cycle k of the issue phase, the wavefront ID is 2·pair + ((k/4) mod 2). A wavefront therefore issues the same quarter of consecutive bundles exactly 8 cycles apart.
- R4: While `issue_vld` is 1, `slot_en` equals `slot_mask`, bit i enabling slot i. Otherwise `slot_en` is 0.
- R5: If W is odd, the cycles in which the missing partner wavefront W would issue have `issue_vld` at 0, so the lone wavefront stalls 4 cycles between its bundles.
- R6: `done` is high for exactly one cycle, at k = 8·N·P + 7, and `cycle_cnt` then equals 8·N·P + 8. With one bundle, that gives 16, 24 and 40 for 2, 4 and 8 wavefronts. `busy` is low in the following cycle.
- R7: A `start` pulse while `busy` is high has no effect on the schedule, and changes to the count inputs in that pulse have no effect either. A `start` pulse with a zero wavefront count or a zero bundle count leaves `busy` low.
- R8: `cycle_cnt` equals k+1 in busy cycle k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| wave_cnt | input | 4 | Number of wavefronts, 0..8 |
| bndl_cnt | input | 5 | Number of bundles, 0..16 |
| slot_mask | input | 4 | Slot-valid mask of the bundle named by `issue_bndl` |
| busy | output | 1 | Run in progress |
| issue_vld | output | 1 | A quarter issues this cycle |
| issue_wave | output | 3 | Wavefront ID being issued |
| issue_qtr | output | 2 | Quarter (16-element group) being issued |
| issue_bndl | output | 4 | Bundle index being issued |
| slot_en | output | 4 | Per-slot enables to the engine |
| done | output | 1 | One-cycle end-of-run pulse |
| cycle_cnt | output | 16 | Busy cycles elapsed in the current run |

## Verification
The bench sweeps every wavefront count from 1 to 8 against bundle counts 1 to 4. Even counts show the full ping-pong between the two wavefronts of a pair. Odd counts show the idle half-slots of the lone last wavefront, and bundle counts above one show that a pair finishes before the next one starts. The slot mask is a different function of the bundle index in each run, so enables tied to the wrong bundle or leaking into idle cycles show up. Every run also carries a mid-run `start` pulse with altered counts, and two further starts carry zero counts, to show that both kinds of start are ignored.

// File: rtl/vliw_wave_seq.sv
module vliw_wave_seq #(
  parameter int MAX_WAVES   = 8,
  parameter int MAX_BUNDLES = 16,
  parameter int SLOTS       = 4,
  parameter int CNT_W       = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [$clog2(MAX_WAVES+1)-1:0]   wave_cnt,
  input  logic [$clog2(MAX_BUNDLES+1)-1:0] bndl_cnt,
  input  logic [SLOTS-1:0]                 slot_mask,
  output logic                             busy,
  output logic                             issue_vld,
  output logic [$clog2(MAX_WAVES)-1:0]     issue_wave,
  output logic [1:0]                       issue_qtr,
  output logic [$clog2(MAX_BUNDLES)-1:0]   issue_bndl,
  output logic [SLOTS-1:0]                 slot_en,
  output logic                             done,
  output logic [CNT_W-1:0]                 cycle_cnt
);
  localparam int WCW = $clog2(MAX_WAVES+1);
  localparam int WIW = $clog2(MAX_WAVES);
  localparam int BCW = $clog2(MAX_BUNDLES+1);
  localparam int BIW = $clog2(MAX_BUNDLES);
  localparam int LAT = 8;

  logic [WCW-1:0]   wv_q;
  logic [BCW-1:0]   bn_q;
  logic [1:0]       qtr;
  logic             half;
  logic [BIW-1:0]   bndl;
  logic [WIW-1:0]   pair;
  logic             drain;
  logic [2:0]       dcnt;
  logic [CNT_W-1:0] cyc;

  logic lone, last_b, last_p;
  assign lone   = half && (int'({pair, 1'b1}) >= int'(wv_q));
  assign last_b = int'(bndl) + 1 >= int'(bn_q);
  assign last_p = int'({pair, 1'b1}) + 1 >= int'(wv_q);

  assign issue_vld  = busy && !drain && !lone;
  assign issue_wave = WIW'({pair, half});
  assign issue_qtr  = qtr;
  assign issue_bndl = bndl;
  assign slot_en    = issue_vld ? slot_mask : '0;
  assign done       = busy && drain && (int'(dcnt) == LAT - 1);
  assign cycle_cnt  = cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; wv_q <= '0; bn_q <= '0; qtr <= '0; half <= 1'b0;
      bndl <= '0; pair <= '0; drain <= 1'b0; dcnt <= '0; cyc <= '0;
    end else if (!busy) begin
      if (start && wave_cnt != '0 && bndl_cnt != '0) begin
        busy <= 1'b1; wv_q <= wave_cnt; bn_q <= bndl_cnt;
        qtr <= '0; half <= 1'b0; bndl <= '0; pair <= '0;
        drain <= 1'b0; dcnt <= '0; cyc <= CNT_W'(1);
      end
    end else begin
      cyc <= cyc + 1'b1;
      if (drain) begin
        dcnt <= dcnt + 1'b1;
        if (int'(dcnt) == LAT - 1) busy <= 1'b0;
      end else begin
        qtr <= qtr + 1'b1;
        if (qtr == 2'd3) begin
          half <= ~half;
          if (half) begin
            if (last_b) begin
              bndl <= '0;
              pair <= pair + 1'b1;
              if (last_p) drain <= 1'b1;
            end else begin
              bndl <= bndl + 1'b1;
            end
          end
        end
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!issue_vld && !done && slot_en == '0));
  p_quarter_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && issue_qtr != 2'd3) |=>
      (issue_vld && issue_qtr == $past(issue_qtr) + 2'd1 && issue_wave == $past(issue_wave)));
  p_slot_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en & ~slot_mask) == '0);
  p_lone_wave_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> int'(issue_wave) < int'(wv_q));
  p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  p_cnt_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cycle_cnt == CNT_W'(1));
endmodule

// File: tb/vliw_wave_seq_bench.sv
module vliw_wave_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] wave_cnt = '0;
  logic [4:0] bndl_cnt = '0;
  logic [3:0] slot_mask;
  logic busy, issue_vld, done;
  logic [2:0] issue_wave;
  logic [1:0] issue_qtr;
  logic [3:0] issue_bndl, slot_en;
  logic [15:0] cycle_cnt;

  int vectors = 0, errors = 0, seed = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  function automatic logic [3:0] mask_of(int b, int s);
    return 4'((b * 5 + s * 3 + 1) % 16);
  endfunction

  always_comb slot_mask = mask_of(int'(issue_bndl), seed);

  vliw_wave_seq u_vliw_wave_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wave_cnt(wave_cnt), .bndl_cnt(bndl_cnt),
    .slot_mask(slot_mask), .busy(busy), .issue_vld(issue_vld), .issue_wave(issue_wave),
    .issue_qtr(issue_qtr), .issue_bndl(issue_bndl), .slot_en(slot_en), .done(done),
    .cycle_cnt(cycle_cnt));

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(int w, int n);
    int pairs, iend, total;
    pairs = (w + 1) / 2;
    iend  = 8 * n * pairs;
    total = iend + 8;
    @(negedge clk);
    wave_cnt = 4'(w); bndl_cnt = 5'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < total; k++) begin
      bit ev;
      int q, h, b, p, wv;
      ev = 0; q = k % 4; h = (k / 4) % 2; b = 0; p = 0; wv = 0;
      if (k < iend) begin
        b = (k / 8) % n; p = k / (8 * n); wv = 2 * p + h;
        ev = !(h == 1 && wv >= w);
      end
      chk(busy == 1'b1, "R7 busy", int'(busy), 1);
      chk(int'(cycle_cnt) == k + 1, "R8 cycle_cnt", int'(cycle_cnt), k + 1);
      chk(issue_vld == ev, "R5 issue_vld", int'(issue_vld), int'(ev));
      if (ev) begin
        chk(int'(issue_qtr) == q, "R2 quarter", int'(issue_qtr), q);
        chk(int'(issue_bndl) == b, "R2 bundle", int'(issue_bndl), b);
        chk(int'(issue_wave) == wv, "R3 wave", int'(issue_wave), wv);
        chk(slot_en == mask_of(b, seed), "R4 slot_en", int'(slot_en), int'(mask_of(b, seed)));
      end else begin
        chk(slot_en == 4'd0, "R4 slot_en idle", int'(slot_en), 0);
      end
      chk(done == (k == total - 1), "R6 done", int'(done), int'(k == total - 1));
      if (k == total - 1)
        chk(int'(cycle_cnt) == total, "R6 cycle_cnt", int'(cycle_cnt), total);
      if (k == 3) begin
        start = 1'b1; wave_cnt = 4'(w ^ 3); bndl_cnt = 5'(n + 1);
      end else begin
        start = 1'b0; wave_cnt = 4'(w); bndl_cnt = 5'(n);
      end
      @(negedge clk);
    end
    chk(busy == 1'b0, "R6 busy after done", int'(busy), 0);
    chk(issue_vld == 1'b0 && done == 1'b0, "R1 idle outputs", int'(issue_vld), 0);
  endtask

  task automatic zero_start(int w, int n);
    @(negedge clk);
    wave_cnt = 4'(w); bndl_cnt = 5'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R7 zero-count start", int'(busy), 0);
    @(negedge clk);
    chk(issue_vld == 1'b0 && slot_en == 4'd0, "R1 quiet after zero start", int'(issue_vld), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(issue_vld == 1'b0 && done == 1'b0, "R1 reset outputs", int'(issue_vld), 0);
    chk(slot_en == 4'd0, "R1 reset slot_en", int'(slot_en), 0);
    zero_start(0, 3);
    zero_start(4, 0);
    for (int w = 1; w <= 8; w++)
      for (int n = 1; n <= 4; n++) begin
        seed = w * 7 + n;
        run(w, n);
      end
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule